// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder with Bank State Tracking

This block sits on the memory side of a two-bank synchronous DRAM. At every rising clock edge it samples chip select, the row strobe, the column strobe, write enable, clock enable, the bank bit and the address bus. It turns that sample into exactly one command code for the cycle. The block also records whether each bank is idle or open, and which row each open bank holds. It pulses an error flag when a command breaks the bank-state rules.

Address bit 9 has two meanings. On a read or a write it requests an automatic close at the end of the burst. On a precharge it chooses between closing one bank and closing both banks. When a burst that requested the automatic close finishes, the data path drives a burst-complete strobe, and the bank returns to idle. Clock enable gates the next edge, and it also marks self refresh entry and exit. The memory array, data transfer and analog timing are not part of this block.

Top module: `sdram_cmd_front`

## Requirements
- R1: While rst_ni is low, and in the first cycle after reset, cmd_o is 0 (no-op), err_o is 0, bank_active_o is 0 and self_ref_o is 0.
- R2: Each command shows on cmd_o one clock after the edge that samples it. The codes below assume cs_ni=0, an edge that is not suppressed, and the strobes listed as {ras_ni,cas_ni,we_ni}. 000 gives mode register set (code 1). 001 with cke_i=1 gives auto refresh (code 2). 011 gives activate (code 7). 100 gives write (code 8). 101 gives read (code 10). 110 and 111 give no-op (code 0).
- R3: When cs_ni=1 at an edge, cmd_o is 0 and no bank state changes, whatever the strobe, bank and address values are.
- R4: If cke_i is sampled low at one edge, the next edge is suppressed: it decodes as no-op and changes no bank state.
- R5: Strobes 001 with cke_i=0 give self refresh entry (code 3) and set self_ref_o. While self_ref_o is set, every edge with cke_i=0 decodes as no-op. The first edge with cke_i=1 gives code 4 and clears self_ref_o.
- R6: An activate to an idle bank sets that bank's bit in bank_active_o and stores addr_i[9:0] in that bank's open_row_o slot. Bank A is ba_i=0, which uses bit 0 and slot [9:0]. Bank B is ba_i=1, which uses bit 1 and slot [19:10].
- R7: Strobes 010 give a precharge. With addr_i[9]=0 it closes only the bank named by ba_i (code 5). With addr_i[9]=1 it closes both banks and ignores ba_i (code 6).
- R8: A read or write with addr_i[9]=1 gives code 11 for a read and code 9 for a write. Its bank stays open until the edge at which burst_done_i is high, and after that edge the bank is idle. A read or write with addr_i[9]=0 leaves the bank open, even if burst_done_i pulses.
- R9: A read or write to an idle bank, or an activate to an open bank, still reports its code. In that case err_o is 1 for that cycle and bank state does not change.
- R10: A mode register set, an auto refresh or a self refresh entry while any bank is open raises err_o. An illegal self refresh entry does not set self_ref_o.
- R11: When burst_done_i is high at the same edge as a command, any bank waiting for its automatic close is treated as idle by that command.
- R12: After a read or write, col_o holds addr_i[7:0] and cmd_bank_o holds ba_i from that command. Both hold their values until the next read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 1 | Bank select (0 = A, 1 = B) |
| addr_i | input | 10 | Row / column address; bit 9 is the auto-close or all-bank flag |
| burst_done_i | input | 1 | Burst-complete strobe from the data path |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | One-cycle illegal-sequence flag |
| cmd_bank_o | output | 1 | Bank of the last read or write |
| col_o | output | 8 | Column of the last read or write |
| bank_active_o | output | 2 | Per-bank open flag |
| open_row_o | output | 20 | Open row per bank, bank B in the upper slot |
| self_ref_o | output | 1 | Self refresh in progress |

## Verification
Two things can meet in the same cycle: the burst-complete strobe that closes a bank, and a new command aimed at that same bank. The bench starts a read with automatic close on bank A. It then drives burst_done_i high at the same edge as a plain read to bank A. It expects that read to be flagged as an access to an idle bank, with both banks idle afterwards. A separate case applies the strobe while chip select is high, to check that the strobe alone closes a pending bank. A third case checks that a bank opened without automatic close stays open through a strobe.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int NUM_BANKS = 2;
  localparam int ROW_W     = 10;
  localparam int COL_W     = 8;
  localparam int ADDR_W    = 10;
  localparam int AP_BIT    = 9;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_MRS      = 4'd1,
    CMD_REF      = 4'd2,
    CMD_SREF_IN  = 4'd3,
    CMD_SREF_OUT = 4'd4,
    CMD_PRE      = 4'd5,
    CMD_PRE_ALL  = 4'd6,
    CMD_ACT      = 4'd7,
    CMD_WR       = 4'd8,
    CMD_WR_AP    = 4'd9,
    CMD_RD       = 4'd10,
    CMD_RD_AP    = 4'd11
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int NB  = NUM_BANKS,
  parameter int AW  = ADDR_W,
  parameter int APB = AP_BIT,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          edge_en_i,
  input  logic          cke_i,
  input  logic          cs_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic [BW-1:0] ba_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] eff_active_i,
  output cmd_e          cmd_o,
  output logic          err_o,
  output logic          sref_enter_o,
  output logic [NB-1:0] act_hit_o,
  output logic [NB-1:0] pre_hit_o,
  output logic [NB-1:0] acc_hit_o,
  output logic          auto_pre_o
);
  logic any_open, sel_open, ap;
  assign any_open   = |eff_active_i;
  assign sel_open   = eff_active_i[ba_i];
  assign ap         = addr_i[APB];
  assign auto_pre_o = ap;

  always_comb begin
    cmd_o        = CMD_NOP;
    err_o        = 1'b0;
    sref_enter_o = 1'b0;
    act_hit_o    = '0;
    pre_hit_o    = '0;
    acc_hit_o    = '0;
    if (edge_en_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000: begin
          cmd_o = CMD_MRS;
          err_o = any_open;
        end
        3'b001: begin
          cmd_o        = cke_i ? CMD_REF : CMD_SREF_IN;
          err_o        = any_open;
          sref_enter_o = !cke_i && !any_open;
        end
        3'b010: begin
          if (ap) begin
            cmd_o     = CMD_PRE_ALL;
            pre_hit_o = '1;
          end else begin
            cmd_o           = CMD_PRE;
            pre_hit_o[ba_i] = 1'b1;
          end
        end
        3'b011: begin
          cmd_o = CMD_ACT;
          if (sel_open) err_o = 1'b1;
          else          act_hit_o[ba_i] = 1'b1;
        end
        3'b100, 3'b101: begin
          if (we_ni) cmd_o = ap ? CMD_RD_AP : CMD_RD;
          else       cmd_o = ap ? CMD_WR_AP : CMD_WR;
          if (!sel_open) err_o = 1'b1;
          else           acc_hit_o[ba_i] = 1'b1;
        end
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_cmd_pkg::*;
#(
  parameter int RW = ROW_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_hit_i,
  input  logic          pre_hit_i,
  input  logic          acc_hit_i,
  input  logic          auto_pre_i,
  input  logic          burst_done_i,
  input  logic [RW-1:0] row_i,
  output logic          active_o,
  output logic          eff_active_o,
  output logic [RW-1:0] row_o
);
  logic pend_q, close_now;
  assign close_now    = pend_q && burst_done_i;
  assign eff_active_o = active_o && !close_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      pend_q   <= 1'b0;
      row_o    <= '0;
    end else if (act_hit_i) begin
      active_o <= 1'b1;
      pend_q   <= 1'b0;
      row_o    <= row_i;
    end else if (pre_hit_i || close_now) begin
      active_o <= 1'b0;
      pend_q   <= 1'b0;
    end else if (acc_hit_i) begin
      pend_q   <= auto_pre_i;
    end
  end

  assert_act_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_hit_i |=> (active_o && row_o == $past(row_i)));
  assert_pre_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_hit_i && !act_hit_i) |=> !active_o);
  assert_plain_stays_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_hit_i && !auto_pre_i && !pre_hit_i) |=> (active_o && $stable(row_o)));
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int NB  = NUM_BANKS,
  parameter int RW  = ROW_W,
  parameter int CW  = COL_W,
  parameter int AW  = ADDR_W,
  parameter int APB = AP_BIT,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             cs_ni,
  input  logic             ras_ni,
  input  logic             cas_ni,
  input  logic             we_ni,
  input  logic [BW-1:0]    ba_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             burst_done_i,
  output logic [3:0]       cmd_o,
  output logic             err_o,
  output logic [BW-1:0]    cmd_bank_o,
  output logic [CW-1:0]    col_o,
  output logic [NB-1:0]    bank_active_o,
  output logic [NB*RW-1:0] open_row_o,
  output logic             self_ref_o
);
  logic          cke_q, edge_en, dec_err, sref_enter, auto_pre;
  cmd_e          dec_cmd;
  logic [NB-1:0] eff_active, act_hit, pre_hit, acc_hit;

  assign edge_en = cke_q && !self_ref_o;

  sdram_cmd_decode #(.NB(NB), .AW(AW), .APB(APB)) u_dec (
    .edge_en_i   (edge_en),
    .cke_i       (cke_i),
    .cs_ni       (cs_ni),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .we_ni       (we_ni),
    .ba_i        (ba_i),
    .addr_i      (addr_i),
    .eff_active_i(eff_active),
    .cmd_o       (dec_cmd),
    .err_o       (dec_err),
    .sref_enter_o(sref_enter),
    .act_hit_o   (act_hit),
    .pre_hit_o   (pre_hit),
    .acc_hit_o   (acc_hit),
    .auto_pre_o  (auto_pre)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_bank_track #(.RW(RW)) u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_hit_i   (act_hit[b]),
      .pre_hit_i   (pre_hit[b]),
      .acc_hit_i   (acc_hit[b]),
      .auto_pre_i  (auto_pre),
      .burst_done_i(burst_done_i),
      .row_i       (addr_i[RW-1:0]),
      .active_o    (bank_active_o[b]),
      .eff_active_o(eff_active[b]),
      .row_o       (open_row_o[b*RW +: RW])
    );
  end

  logic is_access;
  assign is_access = dec_cmd inside {CMD_RD, CMD_RD_AP, CMD_WR, CMD_WR_AP};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q      <= 1'b1;
      self_ref_o <= 1'b0;
      cmd_o      <= CMD_NOP;
      err_o      <= 1'b0;
      cmd_bank_o <= '0;
      col_o      <= '0;
    end else begin
      cke_q <= cke_i;
      err_o <= dec_err;
      if (self_ref_o) begin
        // exit on first edge with clock enable high
        cmd_o <= cke_i ? CMD_SREF_OUT : CMD_NOP;
        if (cke_i) self_ref_o <= 1'b0;
      end else begin
        cmd_o <= dec_cmd;
        if (sref_enter) self_ref_o <= 1'b1;
      end
      if (is_access) begin
        cmd_bank_o <= ba_i;
        col_o      <= addr_i[CW-1:0];
      end
    end
  end

  // arms $past-based checks after the first sampled edge
  logic chk_armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_armed <= 1'b0;
    else         chk_armed <= 1'b1;
  end

  assert_cs_nop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_armed && $past(cs_ni) && !$past(self_ref_o)) |-> (cmd_o == CMD_NOP));
  assert_cke_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_armed && !$past(cke_q) && !$past(self_ref_o) && !self_ref_o)
      |-> (cmd_o == CMD_NOP && !err_o));
  assert_sref_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_o |-> (bank_active_o == '0 && cmd_o inside {CMD_NOP, CMD_SREF_IN}));
  assert_err_keeps_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_armed && err_o && !$past(burst_done_i)) |-> $stable(bank_active_o));
  assert_err_no_sref_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_SREF_IN && err_o) |-> !self_ref_o);
endmodule

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cke, cs_n, ras_n, cas_n, we_n, ba, bd;
  logic [9:0] addr;
  logic [3:0] cmd;
  logic err, cbank, sref;
  logic [7:0] col;
  logic [1:0] act;
  logic [19:0] rows;

  sdram_cmd_front dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .burst_done_i(bd),
    .cmd_o(cmd), .err_o(err), .cmd_bank_o(cbank), .col_o(col),
    .bank_active_o(act), .open_row_o(rows), .self_ref_o(sref)
  );

  typedef struct packed {
    logic       cke, cs_n, ras_n, cas_n, we_n, ba;
    logic [9:0] addr;
    logic       bd;
    logic [3:0] cmd;
    logic       err;
    logic [1:0] act;
    logic       sr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{1,1,0,0,0,0,10'h000,0, 0,0,2'b00,0, 3},
    '{1,0,0,0,0,0,10'h000,0, 1,0,2'b00,0, 2},
    '{1,0,0,0,1,0,10'h000,0, 2,0,2'b00,0, 2},
    '{1,0,0,1,1,0,10'h155,0, 7,0,2'b01,0, 6},
    '{1,0,0,1,1,0,10'h000,0, 7,1,2'b01,0, 9},
    '{1,0,1,0,1,1,10'h000,0,10,1,2'b01,0, 9},
    '{1,0,0,1,1,1,10'h2AA,0, 7,0,2'b11,0, 6},
    '{1,0,0,0,0,0,10'h000,0, 1,1,2'b11,0,10},
    '{1,0,1,0,0,0,10'h012,0, 8,0,2'b11,0, 2},
    '{1,0,1,0,1,1,10'h203,0,11,0,2'b11,0, 8},
    '{1,1,1,1,1,0,10'h000,1, 0,0,2'b01,0, 8},
    '{1,0,1,0,1,0,10'h200,0,11,0,2'b01,0, 8},
    '{1,0,1,0,1,0,10'h000,1,10,1,2'b00,0,11},
    '{1,0,0,1,1,0,10'h0F0,0, 7,0,2'b01,0, 6},
    '{1,0,0,1,0,1,10'h000,0, 5,0,2'b01,0, 7},
    '{1,0,0,1,1,1,10'h001,0, 7,0,2'b11,0, 6},
    '{1,0,0,1,0,0,10'h000,0, 5,0,2'b10,0, 7},
    '{1,0,0,1,0,1,10'h200,0, 6,0,2'b00,0, 7},
    '{1,0,1,0,0,0,10'h000,0, 8,1,2'b00,0, 9},
    '{1,1,0,1,1,0,10'h000,0, 0,0,2'b00,0, 3},
    '{0,1,1,1,1,0,10'h000,0, 0,0,2'b00,0, 4},
    '{1,0,0,1,1,0,10'h000,0, 0,0,2'b00,0, 4},
    '{1,0,0,1,1,0,10'h000,0, 7,0,2'b01,0, 6},
    '{0,0,0,0,1,0,10'h000,0, 3,1,2'b01,0,10},
    '{1,1,1,1,1,0,10'h000,0, 0,0,2'b01,0, 4},
    '{1,0,0,1,0,0,10'h200,0, 6,0,2'b00,0, 7},
    '{0,0,0,0,1,0,10'h000,0, 3,0,2'b00,1, 5},
    '{0,0,0,1,1,0,10'h000,0, 0,0,2'b00,1, 5},
    '{1,1,1,1,1,0,10'h000,0, 4,0,2'b00,0, 5},
    '{1,0,0,1,1,1,10'h000,0, 7,0,2'b10,0, 6},
    '{1,0,1,0,0,1,10'h280,0, 9,0,2'b10,0, 8},
    '{1,1,1,1,1,0,10'h000,1, 0,0,2'b00,0, 8}
  };

  int total = 0;
  int bad = 0;

  function automatic string rname(int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                       input logic w, input logic b, input logic [9:0] a, input logic d);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; bd = d;
  endtask

  task automatic idle_in();
    drive(1, 1, 1, 1, 1, 0, 10'h000, 0);
  endtask

  task automatic do_reset();
    idle_in();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 during reset", {cmd, err, act, sref}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {cmd, err, act, sref}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_in();
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].cke, TBL[i].cs_n, TBL[i].ras_n, TBL[i].cas_n, TBL[i].we_n,
            TBL[i].ba, TBL[i].addr, TBL[i].bd);
      @(negedge clk);
      check($sformatf("%s table row %0d", rname(int'(TBL[i].req)), i),
            {cmd, err, act, sref}, {TBL[i].cmd, TBL[i].err, TBL[i].act, TBL[i].sr});
    end

    // R6 open rows of both banks
    do_reset();
    drive(1, 0, 0, 1, 1, 0, 10'h155, 0); @(negedge clk);
    drive(1, 0, 0, 1, 1, 1, 10'h2AA, 0); @(negedge clk);
    check("R6 open rows", rows, {10'h2AA, 10'h155});
    // R9 rejected activate keeps row
    drive(1, 0, 0, 1, 1, 0, 10'h3FF, 0); @(negedge clk);
    check("R9 row kept", {err, rows}, {1'b1, 10'h2AA, 10'h155});
    // R12 column and bank capture
    drive(1, 0, 1, 0, 1, 1, 10'h05C, 0); @(negedge clk);
    check("R12 col/bank", {cbank, col}, {1'b1, 8'h5C});
    drive(1, 0, 0, 1, 0, 0, 10'h200, 0); @(negedge clk);
    check("R12 col held", {cbank, col, cmd}, {1'b1, 8'h5C, 4'd6});
    // R8 plain access survives burst strobe
    drive(1, 0, 0, 1, 1, 0, 10'h011, 0); @(negedge clk);
    drive(1, 0, 1, 0, 0, 0, 10'h0A7, 0); @(negedge clk);
    drive(1, 1, 1, 1, 1, 0, 10'h000, 1); @(negedge clk);
    check("R8 plain stays open", {act, col, cbank}, {2'b01, 8'hA7, 1'b0});
    // R11 activate same cycle as close: legal
    drive(1, 0, 1, 0, 1, 0, 10'h200, 0); @(negedge clk);
    drive(1, 0, 0, 1, 1, 0, 10'h123, 1); @(negedge clk);
    check("R11 reopen", {cmd, err, act, rows[9:0]}, {4'd7, 1'b0, 2'b01, 10'h123});
    idle_in(); @(negedge clk);
    check("R11 stays open", act, 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule